// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Message Unit

This block links two processors, called side A and side B, through a shared set of one-word mailboxes and doorbells. Each side sees the same 32-bit register window on a simple request bus: four outgoing data words, four incoming data words, a status word and a control word. A word written into outgoing slot n on one side is read from incoming slot n on the other side. Flags in each side's status word follow every handoff, so software knows when a slot may be reused.

Each side can also ring one of four doorbells at its partner. This is done by setting a request bit in its own control word. The partner sees a pending bit, which it clears by writing a one to that bit. Each side has a single interrupt line, formed from its status flags gated by the enables in its control word. Each side has its own asynchronous reset. A side can see when its partner is held in reset. Reset of either side empties the mailboxes in both directions.

Top module: `ipc_msg_unit`

## Requirements
- R1: Byte offsets are 0x0/0x4/0x8/0xC for outgoing slots 0..3, 0x10/0x14/0x18/0x1C for incoming slots 0..3, 0x20 for status and 0x24 for control. A word written to outgoing slot n on one side is returned by a read of incoming slot n on the other side. Read data appears on the cycle after the request.
- R2: A write to outgoing slot n clears the writer's empty flag n (status bit 20+3-n) and sets the partner's full flag n (status bit 24+3-n). A read of incoming slot n clears that full flag and sets the writer's empty flag n again.
- R3: If a side writes outgoing slot n in the same cycle that the partner reads incoming slot n, the read returns the previous word. The full and not-empty state is kept, and the new word is held for the next read.
- R4: Writing 1 to control bit 16+3-n raises doorbell n. It sets the partner's pending bit n (status bit 28+3-n) one cycle later, and in that same cycle the request bit clears by itself. Writing 0 to a request bit has no effect.
- R5: Writing 1 to status bit 28+3-n clears that side's pending bit n.
- R6: A doorbell request made while the partner's pending bit n is still set stays visible in the control word. It is delivered one cycle after the partner clears the pending bit, and the request bit then clears.
- R7: A side's interrupt is high exactly when at least one of these holds for some n: pending n with enable bit 28+3-n set, full n with enable bit 24+3-n set, or empty n with enable bit 20+3-n set.
- R8: After reset the control word reads 0, all empty flags are 1, all full and pending flags are 0, the status word reads 0x00F00000, and the interrupt is low.
- R9: Status bit 9 is 1 while the partner is held in reset. Reset of either side empties all eight mailboxes.
- R10: These writes are ignored: writes to incoming slots, writes to status bits other than the pending bits, and writes to reserved control bits (15:0). Reserved bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock |
| a_rst_ni | input | 1 | Side A asynchronous reset, active low |
| b_rst_ni | input | 1 | Side B asynchronous reset, active low |
| a_req_i | input | 1 | Side A bus request |
| a_we_i | input | 1 | Side A write (1) or read (0) |
| a_addr_i | input | 6 | Side A byte address |
| a_wdata_i | input | 32 | Side A write data |
| a_rdata_o | output | 32 | Side A read data, valid the cycle after a read |
| a_irq_o | output | 1 | Side A interrupt |
| b_req_i | input | 1 | Side B bus request |
| b_we_i | input | 1 | Side B write (1) or read (0) |
| b_addr_i | input | 6 | Side B byte address |
| b_wdata_i | input | 32 | Side B write data |
| b_rdata_o | output | 32 | Side B read data, valid the cycle after a read |
| b_irq_o | output | 1 | Side B interrupt |

## Verification
The collision that matters is one side writing outgoing slot n in the same cycle that its partner drains incoming slot n. The bench drives both requests on the same clock edge. It then judges the outcome from three observations: the partner's read must return the old word, both status words must still show the slot as occupied, and a later read must return the new word. A second overlap is exercised on the doorbell path: a repeated request while the pending bit is still set must wait, and is judged by reading the requester's control word before and after the partner clears the bit.

// File: rtl/ipc_mu_pkg.sv
`timescale 1ns/1ps
package ipc_mu_pkg;
  localparam int NCH = 4;           // channels per direction (power of two)
  localparam int DW  = 32;
  localparam int AW  = 6;           // byte address width
  localparam int WW  = AW - 2;      // word index width
  localparam int CW  = $clog2(NCH);

  // field bases; channel n sits at base + (NCH-1-n)
  localparam int GP_BASE  = 28;
  localparam int RF_BASE  = 24;
  localparam int TE_BASE  = 20;
  localparam int GR_BASE  = 16;
  localparam int PEER_RST = 9;

  localparam logic [WW-1:0] W_STAT = WW'(2*NCH);
  localparam logic [WW-1:0] W_CTRL = WW'(2*NCH + 1);

  function automatic logic [NCH-1:0] mirror(input logic [NCH-1:0] v);
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[i] = v[NCH-1-i];
    return r;
  endfunction
endpackage

// File: rtl/ipc_mu_mailbox.sv
`timescale 1ns/1ps
module ipc_mu_mailbox #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (wr_i) begin
      data_o <= wdata_i;   // write wins over a same-cycle drain
      full_o <= 1'b1;
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end

  // R2 R3
  mbx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (full_o && data_o == $past(wdata_i)));
  // R2
  mbx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> !full_o);
endmodule

// File: rtl/ipc_mu_side.sv
`timescale 1ns/1ps
module ipc_mu_side
  import ipc_mu_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    peer_rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  output logic                    irq_o,
  output logic [NCH-1:0]          tx_wr_o,
  output logic [NCH-1:0]          rx_rd_o,
  input  logic [NCH-1:0][DW-1:0]  tx_data_i,
  input  logic [NCH-1:0]          tx_full_i,
  input  logic [NCH-1:0][DW-1:0]  rx_data_i,
  input  logic [NCH-1:0]          rx_full_i,
  output logic [NCH-1:0]          gir_o,
  input  logic [NCH-1:0]          gp_ack_i,
  input  logic [NCH-1:0]          gp_req_i,
  output logic [NCH-1:0]          gp_ack_o
);
  logic [WW-1:0]  word;
  logic           wr, rd, ctrl_wr, stat_wr;
  logic           unused_lsb;
  logic [NCH-1:0] gie_q, rie_q, tie_q, gir_q, pend_q;
  logic [NCH-1:0] gir_set, gp_clr;
  logic [DW-1:0]  stat_w, ctrl_w;

  assign word       = addr_i[AW-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign wr         = req_i & we_i;
  assign rd         = req_i & ~we_i;
  assign ctrl_wr    = wr && (word == W_CTRL);
  assign stat_wr    = wr && (word == W_STAT);

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    assign tx_wr_o[n] = wr && (word == WW'(n));
    assign rx_rd_o[n] = rd && (word == WW'(NCH + n));
  end

  assign gir_set  = ctrl_wr ? mirror(wdata_i[GR_BASE +: NCH]) : '0;
  assign gp_clr   = stat_wr ? mirror(wdata_i[GP_BASE +: NCH]) : '0;
  assign gp_ack_o = gp_req_i & ~pend_q;   // deliver only into a free pending bit
  assign gir_o    = gir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= '0;
      rie_q  <= '0;
      tie_q  <= '0;
      gir_q  <= '0;
      pend_q <= '0;
    end else begin
      if (ctrl_wr) begin
        gie_q <= mirror(wdata_i[GP_BASE +: NCH]);
        rie_q <= mirror(wdata_i[RF_BASE +: NCH]);
        tie_q <= mirror(wdata_i[TE_BASE +: NCH]);
      end
      gir_q  <= (gir_q & ~gp_ack_i) | gir_set;
      pend_q <= (pend_q & ~gp_clr) | gp_ack_o;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[GP_BASE +: NCH] = mirror(pend_q);
    stat_w[RF_BASE +: NCH] = mirror(rx_full_i);
    stat_w[TE_BASE +: NCH] = mirror(~tx_full_i);
    stat_w[PEER_RST]       = ~peer_rst_ni;
    ctrl_w = '0;
    ctrl_w[GP_BASE +: NCH] = mirror(gie_q);
    ctrl_w[RF_BASE +: NCH] = mirror(rie_q);
    ctrl_w[TE_BASE +: NCH] = mirror(tie_q);
    ctrl_w[GR_BASE +: NCH] = mirror(gir_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd) begin
      if (word[WW-1:CW] == '0)                rdata_o <= tx_data_i[word[CW-1:0]];
      else if (word[WW-1:CW] == (WW-CW)'(1))  rdata_o <= rx_data_i[word[CW-1:0]];
      else if (word == W_STAT)                rdata_o <= stat_w;
      else if (word == W_CTRL)                rdata_o <= ctrl_w;
      else                                    rdata_o <= '0;
    end
  end

  assign irq_o = |(pend_q & gie_q) | |(rx_full_i & rie_q) | |(~tx_full_i & tie_q);

  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[GP_BASE +: NCH] == '0 && wdata_i[RF_BASE +: NCH] == '0
     && wdata_i[TE_BASE +: NCH] == '0) |=> !irq_o);

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    // R4
    gir_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gp_ack_i[n] && !gir_set[n]) |=> !gir_q[n]);
    // R5
    pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gp_clr[n] && pend_q[n]) |=> !pend_q[n]);
    // R6
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gp_req_i[n] && pend_q[n] && !gp_clr[n]) |=> pend_q[n]);
  end
endmodule

// File: rtl/ipc_msg_unit.sv
`timescale 1ns/1ps
module ipc_msg_unit
  import ipc_mu_pkg::*;
(
  input  logic          clk_i,
  input  logic          a_rst_ni,
  input  logic          b_rst_ni,
  input  logic          a_req_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  output logic          a_irq_o,
  input  logic          b_req_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  output logic          b_irq_o
);
  logic                   mbx_rst_n;
  logic [NCH-1:0]         a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
  logic [NCH-1:0][DW-1:0] ab_data, ba_data;
  logic [NCH-1:0]         ab_full, ba_full;
  logic [NCH-1:0]         a_gir, b_gir, a_ack, b_ack;

  // either side in reset empties both directions
  assign mbx_rst_n = a_rst_ni & b_rst_ni;

  for (genvar n = 0; n < NCH; n++) begin : g_mbx
    ipc_mu_mailbox #(.DW(DW)) u_ab (
      .clk_i(clk_i), .rst_ni(mbx_rst_n),
      .wr_i(a_tx_wr[n]), .wdata_i(a_wdata_i), .rd_i(b_rx_rd[n]),
      .data_o(ab_data[n]), .full_o(ab_full[n]));
    ipc_mu_mailbox #(.DW(DW)) u_ba (
      .clk_i(clk_i), .rst_ni(mbx_rst_n),
      .wr_i(b_tx_wr[n]), .wdata_i(b_wdata_i), .rd_i(a_rx_rd[n]),
      .data_o(ba_data[n]), .full_o(ba_full[n]));
  end

  ipc_mu_side u_side_a (
    .clk_i(clk_i), .rst_ni(a_rst_ni), .peer_rst_ni(b_rst_ni),
    .req_i(a_req_i), .we_i(a_we_i), .addr_i(a_addr_i), .wdata_i(a_wdata_i),
    .rdata_o(a_rdata_o), .irq_o(a_irq_o),
    .tx_wr_o(a_tx_wr), .rx_rd_o(a_rx_rd),
    .tx_data_i(ab_data), .tx_full_i(ab_full),
    .rx_data_i(ba_data), .rx_full_i(ba_full),
    .gir_o(a_gir), .gp_ack_i(b_ack), .gp_req_i(b_gir), .gp_ack_o(a_ack));

  ipc_mu_side u_side_b (
    .clk_i(clk_i), .rst_ni(b_rst_ni), .peer_rst_ni(a_rst_ni),
    .req_i(b_req_i), .we_i(b_we_i), .addr_i(b_addr_i), .wdata_i(b_wdata_i),
    .rdata_o(b_rdata_o), .irq_o(b_irq_o),
    .tx_wr_o(b_tx_wr), .rx_rd_o(b_rx_rd),
    .tx_data_i(ba_data), .tx_full_i(ba_full),
    .rx_data_i(ab_data), .rx_full_i(ab_full),
    .gir_o(b_gir), .gp_ack_i(a_ack), .gp_req_i(a_gir), .gp_ack_o(b_ack));
endmodule

// File: tb/ipc_msg_unit_tb_top.sv
`timescale 1ns/1ps
module ipc_msg_unit_tb_top;
  logic        clk = 1'b0;
  logic        a_rst_n = 1'b0, b_rst_n = 1'b0;
  logic        a_req = 1'b0, a_we = 1'b0, b_req = 1'b0, b_we = 1'b0;
  logic [5:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam bit SA = 1'b0, SB = 1'b1;
  localparam logic [5:0] STAT = 6'h20, CTRL = 6'h24;

  always #10 clk = ~clk;  // 50 MHz

  ipc_msg_unit dut_i (
    .clk_i(clk), .a_rst_ni(a_rst_n), .b_rst_ni(b_rst_n),
    .a_req_i(a_req), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wdata),
    .a_rdata_o(a_rdata), .a_irq_o(a_irq),
    .b_req_i(b_req), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wdata),
    .b_rdata_o(b_rdata), .b_irq_o(b_irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic drive(input bit s, input bit we, input logic [5:0] ad, input logic [31:0] d);
    if (s == SA) begin a_req = 1'b1; a_we = we; a_addr = ad; a_wdata = d; end
    else         begin b_req = 1'b1; b_we = we; b_addr = ad; b_wdata = d; end
  endtask

  task automatic idle_bus();
    a_req = 1'b0; a_we = 1'b0; b_req = 1'b0; b_we = 1'b0;
  endtask

  task automatic wr(input bit s, input logic [5:0] ad, input logic [31:0] d);
    @(negedge clk); drive(s, 1'b1, ad, d);
    @(negedge clk); idle_bus();
  endtask

  task automatic rd(input bit s, input logic [5:0] ad, output logic [31:0] q);
    @(negedge clk); drive(s, 1'b0, ad, '0);
    @(negedge clk); idle_bus();
    q = (s == SA) ? a_rdata : b_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] q;
    rd(SA, STAT, q); chk("R8 A status", q, 32'h00F00000);
    rd(SB, STAT, q); chk("R8 B status", q, 32'h00F00000);
    rd(SA, CTRL, q); chk("R8 A control", q, 32'h0);
    chk("R8 irqs", {30'b0, a_irq, b_irq}, 32'h0);
  endtask

  task automatic t_transfer();
    logic [31:0] q;
    wr(SA, 6'h04, 32'hDEADBEEF);
    rd(SA, STAT, q); chk("R2 A empty1 cleared", q, 32'h00B00000);
    rd(SB, STAT, q); chk("R2 B full1 set", q, 32'h04F00000);
    rd(SB, 6'h14, q); chk("R1 B reads slot1", q, 32'hDEADBEEF);
    rd(SB, STAT, q); chk("R2 B full1 cleared", q, 32'h00F00000);
    rd(SA, STAT, q); chk("R2 A empty1 set", q, 32'h00F00000);
    wr(SB, 6'h0C, 32'h0BADF00D);
    rd(SA, 6'h1C, q); chk("R1 A reads slot3", q, 32'h0BADF00D);
  endtask

  task automatic t_irq();
    logic [31:0] q;
    wr(SB, CTRL, 32'h02000000);
    chk("R7 B idle irq", {31'b0, b_irq}, 32'h0);
    wr(SA, 6'h08, 32'h12345678);
    chk("R7 B full irq", {31'b0, b_irq}, 32'h1);
    chk("R7 A no irq", {31'b0, a_irq}, 32'h0);
    rd(SB, 6'h18, q);
    chk("R7 B irq drop", {31'b0, b_irq}, 32'h0);
    wr(SA, CTRL, 32'h00800000);
    chk("R7 A empty irq", {31'b0, a_irq}, 32'h1);
    wr(SA, CTRL, 32'h0);
    wr(SB, CTRL, 32'h0);
    chk("R7 irqs off", {30'b0, a_irq, b_irq}, 32'h0);
  endtask

  task automatic t_doorbell();
    logic [31:0] q;
    wr(SB, CTRL, 32'h10000000);
    wr(SA, CTRL, 32'h00010000);
    rd(SB, STAT, q); chk("R4 B pending3", q, 32'h10F00000);
    rd(SA, CTRL, q); chk("R4 A request self-cleared", q, 32'h0);
    chk("R7 B doorbell irq", {31'b0, b_irq}, 32'h1);
    wr(SA, CTRL, 32'h0);
    rd(SB, STAT, q); chk("R4 zero write no effect", q, 32'h10F00000);
    wr(SB, STAT, 32'h10000000);
    rd(SB, STAT, q); chk("R5 pending3 cleared", q, 32'h00F00000);
    chk("R5 B irq drop", {31'b0, b_irq}, 32'h0);
    wr(SB, CTRL, 32'h0);
  endtask

  task automatic t_queued();
    logic [31:0] q;
    wr(SA, CTRL, 32'h00080000);
    rd(SB, STAT, q); chk("R4 B pending0", q, 32'h80F00000);
    wr(SA, CTRL, 32'h00080000);
    rd(SA, CTRL, q); chk("R6 request held", q, 32'h00080000);
    rd(SB, STAT, q); chk("R6 pending still set", q, 32'h80F00000);
    wr(SB, STAT, 32'h80000000);
    rd(SA, CTRL, q); chk("R6 request delivered", q, 32'h0);
    rd(SB, STAT, q); chk("R6 pending re-set", q, 32'h80F00000);
    wr(SB, STAT, 32'h80000000);
    rd(SB, STAT, q); chk("R5 final clear", q, 32'h00F00000);
  endtask

  task automatic t_ignored();
    logic [31:0] q;
    wr(SB, STAT, 32'h0FFFFFFF);
    rd(SB, STAT, q); chk("R10 status non-pending ignored", q, 32'h00F00000);
    wr(SA, 6'h10, 32'hCAFECAFE);
    rd(SA, STAT, q); chk("R10 A incoming write ignored", q, 32'h00F00000);
    rd(SB, STAT, q); chk("R10 B untouched", q, 32'h00F00000);
    wr(SA, CTRL, 32'hFFF0FFFF);
    rd(SA, CTRL, q); chk("R10 reserved control", q, 32'hFFF00000);
    wr(SA, CTRL, 32'h0);
    rd(SA, 6'h3C, q); chk("R10 unmapped reads 0", q, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] q;
    wr(SA, 6'h0C, 32'h11111111);
    @(negedge clk);
    drive(SA, 1'b1, 6'h0C, 32'h22222222);
    drive(SB, 1'b0, 6'h1C, '0);
    @(negedge clk); idle_bus();
    chk("R3 old word read", b_rdata, 32'h11111111);
    rd(SB, STAT, q); chk("R3 B full3 kept", q, 32'h01F00000);
    rd(SA, STAT, q); chk("R3 A empty3 still clear", q, 32'h00E00000);
    rd(SB, 6'h1C, q); chk("R3 new word held", q, 32'h22222222);
    rd(SA, STAT, q); chk("R2 A empty3 after drain", q, 32'h00F00000);
  endtask

  task automatic t_peer_reset();
    logic [31:0] q;
    wr(SA, 6'h00, 32'hA5A5A5A5);
    wr(SB, 6'h04, 32'h5A5A5A5A);
    @(negedge clk); b_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rd(SA, STAT, q); chk("R9 peer reset flag and mailboxes empty", q, 32'h00F00200);
    @(negedge clk); b_rst_n = 1'b1;
    rd(SA, STAT, q); chk("R9 flag released", q, 32'h00F00000);
    rd(SB, STAT, q); chk("R9 B mailbox emptied", q, 32'h00F00000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    a_rst_n = 1'b1; b_rst_n = 1'b1;
    t_reset();
    t_transfer();
    t_irq();
    t_doorbell();
    t_queued();
    t_ignored();
    t_collide();
    t_peer_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule